// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a slower memory. It holds 4096 lines, and each line is one four-word block tagged by the upper half of a 32-bit byte address. A load that hits returns its word in the same cycle. A load or store that misses holds the processor stalled while the whole block is fetched from memory. The access then replays and hits.

Every store updates the cached line and also enters a four-entry write buffer, which drains to memory one word per accepted write handshake. A store waits only when that buffer is full. A refill read is not issued until the buffer is empty, so memory always sees the writes before any later block fetch.

The processor holds a request, with its address and data, until the cache lowers its stall. Refills use a request/accept handshake followed by four returned beats.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid and no memory request is raised. The first access to any index misses, including address 0, where the tag is 0.
- R2: An access hits only when the line at index addr[15:4] is valid and its stored tag equals addr[31:16]. A read hit completes with cpu_stall low in the cycle it is presented, and cpu_rdata is word addr[3:2] of the line.
- R3: A read miss keeps cpu_stall high. It raises mem_rd_req with mem_rd_addr = {addr[31:4],4'b0}, and holds both unchanged until mem_rd_accept. It takes four beats on mem_rd_valid carrying words 0,1,2,3 of the block in that order. The access then completes as a hit that returns the refilled word.
- R4: The line's tag, valid bit and data are written only in the cycle of the fourth refill beat. A missing access never completes before that beat.
- R5: A store that misses first refills the whole block, then merges its word. The other three words of the line keep the values read from memory.
- R6: Each accepted store writes its word into the line and enqueues the pair ({addr[31:2],2'b00}, data). mem_wr_req holds its address and data stable until mem_wr_ack, and one entry leaves per handshake.
- R7: The buffer holds four entries. A store hit completes without a stall while an entry is free, and stalls while all four are occupied.
- R8: Buffered writes reach memory in store order. mem_rd_req is never raised while the buffer holds an entry.
- R9: Byte offset addr[1:0] has no effect on which word is read or written.
- R10: An access to an index whose line holds a different tag misses. After that refill the line holds the new block, and the old block misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store word |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| cpu_rdata | output | 32 | Load word, valid when a load completes |
| mem_rd_req | output | 1 | Block refill request |
| mem_rd_addr | output | 32 | Block-aligned refill address |
| mem_rd_accept | input | 1 | Memory takes the refill request |
| mem_rd_valid | input | 1 | One refill word is present |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_req | output | 1 | Buffered write offered to memory |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write word |
| mem_wr_ack | input | 1 | Memory takes the offered write |

## Verification
The properties assume that memory asserts mem_rd_accept only while mem_rd_req is high, and that it sends exactly four mem_rd_valid beats after each accept and none at any other time. They also assume the processor keeps its request fields unchanged while stalled. The bench's memory model accepts one request at a time and returns a fixed four-beat burst, with a gap cycle before the third beat. The processor driver changes its inputs only once a request has completed. Write acknowledges are switched off for a stretch so that the buffer fills. No miss is issued during that stretch, so the bench never waits on a refill that cannot proceed.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int unsigned DCW_ADDR_W   = 32;
  localparam int unsigned DCW_DATA_W   = 32;
  localparam int unsigned DCW_IDX_W    = 12;
  localparam int unsigned DCW_WORDS    = 4;
  localparam int unsigned DCW_WB_DEPTH = 4;

  typedef enum logic [1:0] {
    ST_LOOKUP,
    ST_DRAIN,
    ST_REQ,
    ST_FILL
  } dcw_state_e;

endpackage

// File: rtl/dcw_wbuf.sv
module dcw_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full        = (count_q == CNT_W'(DEPTH));
  assign empty       = (count_q == '0);
  assign mem_wr_req  = !empty;
  assign mem_wr_addr = addr_q[rd_ptr_q];
  assign mem_wr_data = data_q[rd_ptr_q];
  assign pop         = mem_wr_req && mem_wr_ack;

  always_ff @(posedge clk) begin
    if (push && !full) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push && !full) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)           rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push && !full, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/dcw_array.sv
module dcw_array #(
  parameter int IDX_W   = 12,
  parameter int TAG_W   = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  localparam int LINES  = 1 << IDX_W,
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [WOFF_W-1:0] st_woff,
  input  logic [DATA_W-1:0] st_data
);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_we) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
      if (fill_we)
        word_q[fill_idx] <= fill_line[w*DATA_W +: DATA_W];
      else if (st_we && st_woff == WOFF_W'(w))
        word_q[st_idx] <= st_data;
    end

    assign rd_line[w*DATA_W +: DATA_W] = word_q[rd_idx];
  end

endmodule

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
  import dcw_pkg::*;
#(
  parameter int WORDS   = 4,
  localparam int BEAT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              hit,
  input  logic              wb_full,
  input  logic              wb_empty,
  input  logic              mem_rd_accept,
  input  logic              mem_rd_valid,
  output logic              lookup,
  output logic              cpu_stall,
  output logic              store_commit,
  output logic              miss_start,
  output logic              mem_rd_req,
  output logic              beat_we,
  output logic              line_fill_we,
  output logic [BEAT_W-1:0] beat_idx
);

  dcw_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q;
  logic              access_ok;

  assign lookup       = (state_q == ST_LOOKUP);
  assign access_ok    = lookup && cpu_req && hit && (!cpu_we || !wb_full);
  assign cpu_stall    = cpu_req && !access_ok;
  assign store_commit = access_ok && cpu_we;
  assign miss_start   = lookup && cpu_req && !hit;
  assign mem_rd_req   = (state_q == ST_REQ);
  assign beat_we      = (state_q == ST_FILL) && mem_rd_valid;
  assign line_fill_we = beat_we && (beat_q == BEAT_W'(WORDS - 1));
  assign beat_idx     = beat_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOOKUP: if (miss_start)    state_d = wb_empty ? ST_REQ : ST_DRAIN;
      ST_DRAIN:  if (wb_empty)      state_d = ST_REQ;
      ST_REQ:    if (mem_rd_accept) state_d = ST_FILL;
      ST_FILL:   if (line_fill_we)  state_d = ST_LOOKUP;
      default:                      state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOOKUP;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REQ) beat_q <= '0;
      else if (beat_we)      beat_q <= beat_q + 1'b1;
    end
  end

endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcw_pkg::*;
#(
  parameter int ADDR_W   = DCW_ADDR_W,
  parameter int DATA_W   = DCW_DATA_W,
  parameter int IDX_W    = DCW_IDX_W,
  parameter int WORDS    = DCW_WORDS,
  parameter int WB_DEPTH = DCW_WB_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_accept,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int OFF_W  = WOFF_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int BUF_W  = DATA_W * (WORDS - 1);

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WOFF_W-1:0] addr_woff(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: WOFF_W];
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WOFF_W-1:0] woff);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < WORDS; i++)
      if (woff == WOFF_W'(i)) w = line[i*DATA_W +: DATA_W];
    return w;
  endfunction

  // Named internal events, observed by the bound checker.
  logic              hit_w;
  logic              lookup_w;
  logic              wb_full_w;
  logic              wb_empty_w;
  logic              wb_push_w;
  logic              line_fill_we_w;
  logic              miss_start_w;
  logic              beat_we_w;
  logic [WOFF_W-1:0] beat_idx_w;

  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic [BLK_W-1:0]  miss_blk_q;
  logic [BUF_W-1:0]  fill_buf_q;
  logic [LINE_W-1:0] fill_line;
  logic              unused_byte_off;

  assign unused_byte_off = ^cpu_addr[BYTE_W-1:0];

  assign hit_w     = line_valid && (line_tag == addr_tag(cpu_addr));
  assign cpu_rdata = pick_word(line_data, addr_woff(cpu_addr));

  dcw_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .hit          (hit_w),
    .wb_full      (wb_full_w),
    .wb_empty     (wb_empty_w),
    .mem_rd_accept(mem_rd_accept),
    .mem_rd_valid (mem_rd_valid),
    .lookup       (lookup_w),
    .cpu_stall    (cpu_stall),
    .store_commit (wb_push_w),
    .miss_start   (miss_start_w),
    .mem_rd_req   (mem_rd_req),
    .beat_we      (beat_we_w),
    .line_fill_we (line_fill_we_w),
    .beat_idx     (beat_idx_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            miss_blk_q <= '0;
    else if (miss_start_w) miss_blk_q <= cpu_addr[ADDR_W-1:OFF_W];
  end

  assign mem_rd_addr = {miss_blk_q, {OFF_W{1'b0}}};

  // Beats arrive in word order; the last one goes straight into the line.
  for (genvar w = 0; w < WORDS - 1; w++) begin : g_fill
    always_ff @(posedge clk) begin
      if (beat_we_w && beat_idx_w == WOFF_W'(w))
        fill_buf_q[w*DATA_W +: DATA_W] <= mem_rd_data;
    end
  end

  assign fill_line = {mem_rd_data, fill_buf_q};

  dcw_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (addr_idx(cpu_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_line  (line_data),
    .fill_we  (line_fill_we_w),
    .fill_idx (miss_blk_q[0 +: IDX_W]),
    .fill_tag (miss_blk_q[BLK_W-1 -: TAG_W]),
    .fill_line(fill_line),
    .st_we    (wb_push_w),
    .st_idx   (addr_idx(cpu_addr)),
    .st_woff  (addr_woff(cpu_addr)),
    .st_data  (cpu_wdata)
  );

  dcw_wbuf #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (WB_DEPTH)
  ) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wb_push_w),
    .push_addr  ({cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}),
    .push_data  (cpu_wdata),
    .full       (wb_full_w),
    .empty      (wb_empty_w),
    .mem_wr_req (mem_wr_req),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .mem_wr_ack (mem_wr_ack)
  );

endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_accept,
  input logic              mem_rd_valid,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic              hit,
  input logic              lookup,
  input logic              wb_full,
  input logic              wb_empty,
  input logic              wb_push,
  input logic              line_fill_we
);

  logic [7:0] beats_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                           beats_seen <= '0;
    else if (mem_rd_req && mem_rd_accept) beats_seen <= '0;
    else if (mem_rd_valid)                beats_seen <= beats_seen + 1'b1;
  end

  AST_REFILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0)); // R3

  AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_accept) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !hit) |-> cpu_stall); // R3

  AST_READ_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && lookup && hit) |-> !cpu_stall); // R2

  AST_LINE_ON_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    line_fill_we |-> (mem_rd_valid && beats_seen == 8'(WORDS - 1))); // R4

  AST_STORE_ENQUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall) |-> wb_push); // R6

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> !wb_push); // R7

  AST_REFILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (wb_empty && !mem_wr_req)); // R8

endmodule

bind dcache_wt dcache_wt_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WORDS (WORDS),
  .OFF_W (OFF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_stall    (cpu_stall),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_accept(mem_rd_accept),
  .mem_rd_valid (mem_rd_valid),
  .mem_wr_req   (mem_wr_req),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ack   (mem_wr_ack),
  .hit          (hit_w),
  .lookup       (lookup_w),
  .wb_full      (wb_full_w),
  .wb_empty     (wb_empty_w),
  .wb_push      (wb_push_w),
  .line_fill_we (line_fill_we_w)
);

// File: tb/dcache_wt_tb.sv
`timescale 1ns/100ps
module dcache_wt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_stall;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req, mem_rd_accept = 1'b0, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        mem_wr_req, mem_wr_ack;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        wr_ack_en = 1'b1;

  assign mem_wr_ack = wr_ack_en;

  always #2 clk = ~clk;

  dcache_wt u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_accept(mem_rd_accept),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack)
  );

  int n_chk = 0, n_fail = 0;
  int beat_cnt = 0;
  int wb_out = 0;

  logic [31:0] mstore [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] rd_q [$];
  logic [63:0] wr_q [$];
  bit          tv [int];
  logic [15:0] tt [int];

  function automatic logic [31:0] init_word(input logic [31:0] wa);
    return wa ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return mstore.exists(wa) ? mstore[wa] : init_word(wa);
  endfunction

  function automatic logic [31:0] cpu_view(input logic [31:0] wa);
    return shadow.exists(wa) ? shadow[wa] : init_word(wa);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: presents one access, pushes expected load data to the scoreboard.
  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output int stalls, output int beats);
    logic [31:0] wa;
    int idx, b0;
    bit hit;
    wa  = {a[31:2], 2'b00};
    idx = int'(a[15:4]);
    hit = tv.exists(idx) && tv[idx] && tt[idx] == a[31:16];
    stalls = 0;
    @(posedge clk); #1;
    b0 = beat_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (!we) rd_q.push_back(cpu_view(wa));
    forever begin
      @(negedge clk);
      if (!cpu_stall) break;
      stalls++;
    end
    beats = beat_cnt - b0;
    if (we) begin
      shadow[wa] = d;
      wr_q.push_back({wa, d});
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
    if (we) wb_out++;
    if (!hit) begin
      chk("R3 miss stalls", 32'(stalls > 0), 32'd1);
      chk("R4 miss completes only after four beats", 32'(beats), 32'd4);
    end else if (!we) begin
      chk("R2 read hit without stall", 32'(stalls), 32'd0);
    end
    tv[idx] = 1'b1;
    tt[idx] = a[31:16];
  endtask

  // Monitor: compares each completing load against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cpu_req && !cpu_we && !cpu_stall) begin
      if (rd_q.size() == 0) begin
        chk("R2 unexpected load completion", 32'd1, 32'd0);
      end else begin
        chk("R2 R3 load data", cpu_rdata, rd_q.pop_front());
      end
    end
  end

  // Memory model, refill side.
  initial begin
    logic [31:0] blk;
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        blk = mem_rd_addr;
        chk("R3 refill address aligned", blk & 32'hF, 32'h0);
        chk("R8 refill only after drain", 32'(wb_out), 32'd0);
        @(posedge clk); #1 mem_rd_accept = 1'b1;
        @(posedge clk); #1 mem_rd_accept = 1'b0;
        for (int b = 0; b < 4; b++) begin
          if (b == 2) begin
            @(posedge clk); #1;
          end
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_word(blk + 32'(4 * b));
          beat_cnt++;
          @(posedge clk); #1 mem_rd_valid = 1'b0;
        end
      end
    end
  end

  // Memory model, write side.
  initial begin
    logic [63:0] e;
    logic [31:0] wa, wd;
    forever begin
      @(negedge clk);
      if (rst_n && mem_wr_req && mem_wr_ack) begin
        wa = mem_wr_addr;
        wd = mem_wr_data;
        if (wr_q.size() == 0) begin
          chk("R6 unexpected memory write", 32'd1, 32'd0);
        end else begin
          e = wr_q.pop_front();
          chk("R8 write order address", wa, e[63:32]);
          chk("R6 write data", wd, e[31:0]);
        end
        @(posedge clk); #1;
        mstore[wa] = wd;
        wb_out--;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int s, b;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no stall after reset", 32'(cpu_stall), 32'd0);
    chk("R1 no refill after reset", 32'(mem_rd_req), 32'd0);
    chk("R1 no write after reset", 32'(mem_wr_req), 32'd0);

    // R1: address 0 carries tag 0 yet must miss
    access(1'b0, 32'h0000_0000, '0, s, b);
    chk("R1 first access misses", 32'(s > 0), 32'd1);

    // R3 read miss, then R2 hits on every word
    access(1'b0, 32'h0001_0020, '0, s, b);
    for (int w = 0; w < 4; w++) access(1'b0, 32'h0001_0020 + 32'(4 * w), '0, s, b);

    // R9 byte offset ignored on reads and stores
    access(1'b0, 32'h0001_0025, '0, s, b);
    access(1'b0, 32'h0001_002B, '0, s, b);
    access(1'b1, 32'h0001_002D, 32'h1111_2222, s, b);
    chk("R9 R7 store hit no stall", 32'(s), 32'd0);
    access(1'b0, 32'h0001_002C, '0, s, b);

    // R6 store hit, read back
    access(1'b1, 32'h0001_0024, 32'hAAAA_5555, s, b);
    access(1'b0, 32'h0001_0024, '0, s, b);

    // R10 conflict at same index, then old block misses again; R8 drain before refill
    access(1'b0, 32'h0002_0024, '0, s, b);
    access(1'b0, 32'h0001_0024, '0, s, b);
    chk("R10 old block misses after replacement", 32'(s > 0), 32'd1);

    // R5 write miss: fetch block then merge
    access(1'b1, 32'h0003_0038, 32'hDEAD_BEEF, s, b);
    chk("R5 write miss refills", 32'(b), 32'd4);
    for (int w = 0; w < 4; w++) access(1'b0, 32'h0003_0030 + 32'(4 * w), '0, s, b);

    // R7: fill the buffer with acknowledges off
    access(1'b0, 32'h0004_0040, '0, s, b);
    wait (wb_out == 0);
    @(posedge clk); #1 wr_ack_en = 1'b0;
    for (int w = 0; w < 4; w++) begin
      access(1'b1, 32'h0004_0040 + 32'(4 * w), 32'h7700_0000 + 32'(w), s, b);
      chk("R7 store with free entry", 32'(s), 32'd0);
    end
    fork
      begin
        access(1'b1, 32'h0004_0044, 32'h5EC0_0D00, s, b);
      end
      begin
        repeat (8) @(negedge clk);
        chk("R7 store stalls while full", 32'(cpu_stall), 32'd1);
        @(posedge clk); #1 wr_ack_en = 1'b1;
      end
    join
    chk("R7 full-buffer stall length", 32'(s >= 7), 32'd1);
    for (int w = 0; w < 4; w++) access(1'b0, 32'h0004_0040 + 32'(4 * w), '0, s, b);

    // R8: evict, then refetch from memory that received the drained writes
    access(1'b0, 32'h0005_0040, '0, s, b);
    for (int w = 0; w < 4; w++) access(1'b0, 32'h0004_0040 + 32'(4 * w), '0, s, b);

    wait (wb_out == 0);
    repeat (4) @(posedge clk);
    chk("R2 scoreboard drained", 32'(rd_q.size()), 32'd0);
    chk("R6 all writes reached memory", 32'(wr_q.size()), 32'd0);
    finish_run();
  end

endmodule